// File: doc/BRIEF.md
# Strobe-Framed Dual-Lane I/Q Sample Receiver

This block turns two serial bit streams, one carrying in-phase samples and one carrying quadrature samples, back into parallel 16-bit I/Q pairs. A framing strobe travels alongside the two lanes. Every signal is sampled only in clock cycles where the bit-clock enable is high. A rising edge of the strobe marks the first bit of a new word. Both lanes are then shifted in together, most significant bit first, until the configured word length has been collected. The finished pair is presented on the outputs with a valid pulse that lasts one clock cycle.

Two configuration inputs control framing. One selects a 16-bit or a 12-bit word. In 12-bit mode the result is widened to 16 bits by placing four zero bits below the received bits. The other input selects the strobe shape: a short pulse on the first bit only, or a level that stays high for the first half of the word. Only the rising edge is used for alignment, so both shapes are aligned the same way. The shape is used only to detect badly formed frames. A sticky error flag records any framing fault. Bits that arrive while no word is open are discarded.

Top module: `iq_lane_rx`

## Requirements
- R1: While reset is asserted, and immediately after it, `out_valid`, `out_i`, `out_q` and `frame_err` are all zero.
- R2: A word opens on an enabled bit where `strobe` is 1 and the previous enabled `strobe` sample was 0. That bit is the most significant bit of the word. Each later enabled bit is shifted in below the bits already collected, and the result appears on `out_i`.
- R3: The Q lane is captured in the same enabled cycles as the I lane, under the same framing, and the result appears on `out_q`.
- R4: When `cfg_short`=1, a word is 12 bits long and is output as the received 12 bits in output bits 15..4, with bits 3..0 set to zero. When `cfg_short`=0, a word is 16 bits long.
- R5: `out_valid` is high for exactly one clock cycle, in the cycle after the clock edge that captures the final bit of a word. `out_i` and `out_q` change only at that edge and hold their values between words.
- R6: Enabled bits that arrive while no word is open (after reset, or after a word has completed) without a strobe rising edge produce no output and leave `out_i` and `out_q` unchanged.
- R7: A strobe rising edge that arrives while a word is still open sets `frame_err`, abandons the partial word, and starts a new word with that bit as its first bit.
- R8: Strobe shape check. With `cfg_level`=0 (pulse), `strobe` must be 0 on every bit of the word after the first. With `cfg_level`=1 (level), `strobe` must be 1 on the first half of the word's bits and 0 on the second half. Any mismatch sets `frame_err`, and the word still completes.
- R9: `frame_err` stays set until reset, or until a clock cycle in which `err_clr`=1 and no new error is detected. A new error in the same cycle as `err_clr` takes priority, so the flag stays set.
- R10: In cycles where `bit_en`=0, the lanes and the strobe are ignored, and framing state does not advance.
- R11: The values of `cfg_short` and `cfg_level` are captured on the first bit of each word. Changing them part-way through a word does not affect that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; the lanes and strobe are sampled only when this is 1 |
| strobe | input | 1 | Framing strobe; a rising edge opens a word |
| lane_i | input | 1 | In-phase serial lane |
| lane_q | input | 1 | Quadrature serial lane |
| cfg_short | input | 1 | 1 = 12-bit words, 0 = 16-bit words |
| cfg_level | input | 1 | 1 = half-word level strobe, 0 = first-bit pulse strobe |
| err_clr | input | 1 | Write-one-to-clear for `frame_err` |
| out_i | output | 16 | Recovered in-phase sample |
| out_q | output | 16 | Recovered quadrature sample |
| out_valid | output | 1 | One-cycle pulse when a new pair is available |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The bench focuses on alignment corner cases.

- A second rising edge is sent part-way through a word. A design that ignored it would emit a word mixing old and new bits. A design that failed to restart would lose the next word.
- Bit-enable gaps are sent while the strobe is held high. A design that sampled the strobe without the enable would see an extra edge.
- The configuration is flipped in the middle of a word. A design that did not capture it at the word start would cut the word short or pad it wrongly.
- Strobes that are held too long or dropped too early check that the shape rule is enforced.
- An error and `err_clr` are made to coincide, to show that the set takes priority over the clear.

// File: rtl/iq_lane_rx_pkg.sv
package iq_lane_rx_pkg;

   localparam int NUM_LANES = 2;
   localparam int LANE_I    = 0;
   localparam int LANE_Q    = 1;

   typedef enum logic {
      SHAPE_PULSE = 1'b0,
      SHAPE_LEVEL = 1'b1
   } strobe_shape_e;

endpackage

// File: rtl/iq_strobe_framer.sv
module iq_strobe_framer
   import iq_lane_rx_pkg::*;
#(
   parameter int FULL_W  = 16,
   parameter int SHORT_W = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic strobe,
   input  logic cfg_short,
   input  logic cfg_level,
   input  logic err_clr,
   output logic word_start,
   output logic bit_shift,
   output logic word_last,
   output logic mode_short,
   output logic frame_err
);

   localparam int             CW    = $clog2(FULL_W + 1);
   localparam logic [CW-1:0]  LEN_F = CW'(FULL_W);
   localparam logic [CW-1:0]  LEN_S = CW'(SHORT_W);

   logic          strb_q;
   logic          busy_q;
   logic          short_q;
   logic          err_q;
   strobe_shape_e shape_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] wlen;
   logic          exp_strb;
   logic          shape_bad;
   logic          early_edge;
   logic          err_set;

   // word framing: a rising edge of the sampled strobe opens a word
   assign word_start = bit_en & strobe & ~strb_q;
   assign bit_shift  = bit_en & busy_q & ~word_start;
   assign wlen       = short_q ? LEN_S : LEN_F;
   assign word_last  = bit_shift & (cnt_q == wlen - 1'b1);

   // strobe level expected at the current bit position for the captured shape
   always_comb begin
      if (shape_q == SHAPE_LEVEL) exp_strb = (cnt_q < (wlen >> 1));
      else                        exp_strb = 1'b0;
   end

   assign shape_bad  = bit_shift & (strobe != exp_strb);
   assign early_edge = word_start & busy_q;
   assign err_set    = early_edge | shape_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q  <= 1'b0;
         busy_q  <= 1'b0;
         short_q <= 1'b0;
         shape_q <= SHAPE_PULSE;
         cnt_q   <= '0;
      end else begin
         if (bit_en) strb_q <= strobe;
         if (word_start) begin
            busy_q  <= 1'b1;
            cnt_q   <= CW'(1);
            short_q <= cfg_short;
            shape_q <= strobe_shape_e'(cfg_level);
         end else if (bit_shift) begin
            if (word_last) busy_q <= 1'b0;
            else           cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
   end

   assign mode_short = short_q;
   assign frame_err  = err_q;

   a_r7_restart_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (word_start && busy_q) |=> (err_q && busy_q && cnt_q == CW'(1)));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr) |=> err_q);

   a_r10_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(cnt_q) && $stable(busy_q) && $stable(strb_q)));

   a_r11_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !word_start) |=> $stable(short_q));

endmodule

// File: rtl/iq_lane_shift.sv
module iq_lane_shift #(
   parameter int FULL_W  = 16,
   parameter int SHORT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_first,
   input  logic              shift_in,
   input  logic              capture,
   input  logic              mode_short,
   input  logic              din,
   output logic [FULL_W-1:0] dout
);

   localparam int PAD = FULL_W - SHORT_W;

   logic [FULL_W-1:0] sh_q;
   logic [FULL_W-1:0] nxt;
   logic [FULL_W-1:0] padded;

   // MSB first: the newest bit always enters at the bottom
   always_comb begin
      if (load_first) nxt = {{(FULL_W-1){1'b0}}, din};
      else            nxt = {sh_q[FULL_W-2:0], din};
   end

   assign padded = {nxt[SHORT_W-1:0], {PAD{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         dout <= '0;
      end else begin
         if (load_first || shift_in) sh_q <= nxt;
         if (capture) dout <= mode_short ? padded : nxt;
      end
   end

   a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && mode_short) |=> (dout[PAD-1:0] == '0));

   a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(dout));

endmodule

// File: rtl/iq_lane_rx.sv
module iq_lane_rx
   import iq_lane_rx_pkg::*;
#(
   parameter int FULL_W  = 16,
   parameter int SHORT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              strobe,
   input  logic              lane_i,
   input  logic              lane_q,
   input  logic              cfg_short,
   input  logic              cfg_level,
   input  logic              err_clr,
   output logic [FULL_W-1:0] out_i,
   output logic [FULL_W-1:0] out_q,
   output logic              out_valid,
   output logic              frame_err
);

   generate
      if (SHORT_W < 2 || SHORT_W >= FULL_W) begin : g_bad_width
         $error("iq_lane_rx: SHORT_W must be at least 2 and below FULL_W");
      end
      if (FULL_W % 2 != 0 || SHORT_W % 2 != 0) begin : g_bad_parity
         $error("iq_lane_rx: word lengths must be even for the level strobe");
      end
   endgenerate

   logic                   word_start;
   logic                   bit_shift;
   logic                   word_last;
   logic                   mode_short;
   logic                   valid_q;
   logic [NUM_LANES-1:0]   lane_bits;
   logic [FULL_W-1:0]      words [NUM_LANES];

   assign lane_bits[LANE_I] = lane_i;
   assign lane_bits[LANE_Q] = lane_q;

   iq_strobe_framer #(
      .FULL_W  (FULL_W),
      .SHORT_W (SHORT_W)
   ) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .strobe     (strobe),
      .cfg_short  (cfg_short),
      .cfg_level  (cfg_level),
      .err_clr    (err_clr),
      .word_start (word_start),
      .bit_shift  (bit_shift),
      .word_last  (word_last),
      .mode_short (mode_short),
      .frame_err  (frame_err)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      iq_lane_shift #(
         .FULL_W  (FULL_W),
         .SHORT_W (SHORT_W)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_first (word_start),
         .shift_in   (bit_shift),
         .capture    (word_last),
         .mode_short (mode_short),
         .din        (lane_bits[g]),
         .dout       (words[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= word_last;
   end

   assign out_i     = words[LANE_I];
   assign out_q     = words[LANE_Q];
   assign out_valid = valid_q;

   a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   a_r6_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en) |=> !out_valid || $past(word_last));

   always_ff @(posedge clk) begin
      if (!rst_n) a_r1_reset_quiet: assert (!out_valid && !frame_err);
   end

endmodule

// File: tb/iq_lane_rx_bench.sv
`timescale 1ns/100ps
module iq_lane_rx_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        strobe = 1'b0;
   logic        lane_i = 1'b0;
   logic        lane_q = 1'b0;
   logic        cfg_short = 1'b0;
   logic        cfg_level = 1'b0;
   logic        err_clr = 1'b0;
   logic [15:0] out_i;
   logic [15:0] out_q;
   logic        out_valid;
   logic        frame_err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   iq_lane_rx u_iq_lane_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .strobe    (strobe),
      .lane_i    (lane_i),
      .lane_q    (lane_q),
      .cfg_short (cfg_short),
      .cfg_level (cfg_level),
      .err_clr   (err_clr),
      .out_i     (out_i),
      .out_q     (out_q),
      .out_valid (out_valid),
      .frame_err (frame_err)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_busy = 0, m_cnt = 0, m_len = 16, m_lvl = 0, m_prev = 0;
   int m_ai = 0, m_aq = 0, m_i = 0, m_q = 0, m_valid = 0, m_err = 0;

   always @(posedge clk or negedge rst_n) begin
      int set_now;
      int e;
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_prev = 0; m_ai = 0; m_aq = 0;
         m_i = 0; m_q = 0; m_valid = 0; m_err = 0;
      end else begin
         set_now = 0;
         m_valid = 0;
         if (bit_en) begin
            if (strobe && !m_prev) begin
               if (m_busy) set_now = 1;
               m_busy = 1; m_cnt = 1;
               m_len = cfg_short ? 12 : 16;
               m_lvl = cfg_level;
               m_ai = lane_i; m_aq = lane_q;
            end else if (m_busy) begin
               e = m_lvl ? (m_cnt < m_len / 2) : 0;
               if (int'(strobe) != e) set_now = 1;
               m_ai = (m_ai << 1) | lane_i;
               m_aq = (m_aq << 1) | lane_q;
               if (m_cnt == m_len - 1) begin
                  m_busy = 0; m_valid = 1;
                  m_i = (m_ai << (16 - m_len)) & 'hFFFF;
                  m_q = (m_aq << (16 - m_len)) & 'hFFFF;
               end else m_cnt++;
            end
            m_prev = strobe;
         end
         if (set_now) m_err = 1;
         else if (err_clr) m_err = 0;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         chk(out_valid, m_valid, "R5 model valid");
         chk(out_i, m_i, "R2 R4 model I word");
         chk(out_q, m_q, "R3 model Q word");
         chk(frame_err, m_err, "R7 R8 R9 model error flag");
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive_bit(input logic i, input logic q, input logic s, input logic en);
      lane_i = i; lane_q = q; strobe = s; bit_en = en;
      @(negedge clk);
   endtask

   // send bits [from..to-1] of an n-bit word; strobe pattern from smask (MSB = first bit)
   task automatic send_bits(input int iv, input int qv, input int n, input int smask,
                            input int from, input int to, input bit gaps, input bit clr_first);
      for (int k = from; k < to; k++) begin
         err_clr = clr_first && (k == from);
         drive_bit(1'((iv >> (n-1-k)) & 1), 1'((qv >> (n-1-k)) & 1),
                   1'((smask >> (n-1-k)) & 1), 1'b1);
         err_clr = 1'b0;
         if (gaps && k != to - 1) drive_bit(1'b1, 1'b0, 1'b1, 1'b0);
      end
   endtask

   function automatic int pulse_mask(input int n);
      return 1 << (n - 1);
   endfunction

   function automatic int level_mask(input int n);
      return ((1 << (n / 2)) - 1) << (n - n / 2);
   endfunction

   task automatic idle(input int cycles);
      for (int c = 0; c < cycles; c++) drive_bit(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic clear_err();
      err_clr = 1'b1;
      idle(1);
      err_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet outputs in reset
      chk(out_valid, 0, "R1 valid in reset");
      chk(out_i, 0, "R1 I in reset");
      chk(frame_err, 0, "R1 error in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_q, 0, "R1 Q after reset");

      // R6: bits before the first strobe edge are discarded
      for (int k = 0; k < 6; k++) begin
         drive_bit(1'(k & 1), 1'b1, 1'b0, 1'b1);
         chk(out_valid, 0, "R6 no valid before strobe");
      end
      chk(out_i, 0, "R6 I untouched before strobe");

      // R2 R3 R5: 16-bit word, pulse strobe
      send_bits('hA5C3, 'h3C5A, 16, pulse_mask(16), 0, 16, 0, 0);
      chk(out_valid, 1, "R5 valid after last bit");
      chk(out_i, 'hA5C3, "R2 I word MSB first");
      chk(out_q, 'h3C5A, "R3 Q word parallel");
      chk(frame_err, 0, "R8 legal pulse strobe no error");
      idle(1);
      chk(out_valid, 0, "R5 valid lasts one cycle");
      chk(out_i, 'hA5C3, "R5 I holds between words");

      // R10: enable gaps with strobe held high in the gaps, back-to-back words
      send_bits('h8001, 'h7FFE, 16, pulse_mask(16), 0, 16, 1, 0);
      chk(out_i, 'h8001, "R10 gaps ignored I");
      chk(out_q, 'h7FFE, "R10 gaps ignored Q");
      send_bits('hFFFF, 'h0000, 16, pulse_mask(16), 0, 16, 1, 0);
      chk(out_i, 'hFFFF, "R10 back-to-back word");
      chk(frame_err, 0, "R10 no error from gaps");

      // R4: 12-bit words with level strobe
      cfg_short = 1'b1; cfg_level = 1'b1;
      send_bits('hABC, 'h123, 12, level_mask(12), 0, 12, 0, 0);
      chk(out_i, 'hABC0, "R4 I padded with zeros");
      chk(out_q, 'h1230, "R4 Q padded with zeros");
      chk(frame_err, 0, "R8 legal level strobe no error");
      cfg_short = 1'b0; cfg_level = 1'b0;

      // R6: bits after a finished word without a new edge are discarded
      for (int k = 0; k < 3; k++) begin
         drive_bit(1'b1, 1'b1, 1'b0, 1'b1);
         chk(out_valid, 0, "R6 no valid after word");
      end
      chk(out_i, 'hABC0, "R6 I unchanged after word");

      // R7: early edge restarts; err_clr on the same cycle loses (R9)
      send_bits('hFFFF, 'hFFFF, 16, pulse_mask(16), 0, 5, 0, 0);
      send_bits('h1234, 'h4321, 16, pulse_mask(16), 0, 16, 0, 1);
      chk(frame_err, 1, "R7 early edge sets error, R9 set wins over clear");
      chk(out_i, 'h1234, "R7 capture restarted I");
      chk(out_q, 'h4321, "R7 capture restarted Q");

      // R9: write-one-to-clear
      clear_err();
      chk(frame_err, 0, "R9 error cleared");

      // R8: pulse strobe held for two bits
      send_bits('h0F0F, 'hF0F0, 16, 'hC000, 0, 16, 0, 0);
      chk(frame_err, 1, "R8 pulse held too long");
      chk(out_i, 'h0F0F, "R8 word completes despite error");
      clear_err();

      // R8: level strobe dropped early in 12-bit mode
      cfg_short = 1'b1; cfg_level = 1'b1;
      send_bits('h5A5, 'hA5A, 12, 'hE00, 0, 12, 0, 0);
      chk(frame_err, 1, "R8 level dropped early");
      chk(out_i, 'h5A50, "R8 12-bit word still output");
      clear_err();

      // R11: configuration flipped mid-word has no effect on that word
      cfg_short = 1'b0; cfg_level = 1'b0;
      send_bits('hC3A5, 'h5A3C, 16, pulse_mask(16), 0, 4, 0, 0);
      cfg_short = 1'b1; cfg_level = 1'b1;
      send_bits('hC3A5, 'h5A3C, 16, pulse_mask(16), 4, 16, 0, 0);
      chk(out_valid, 1, "R11 full 16-bit length kept");
      chk(out_i, 'hC3A5, "R11 no padding mid-word");
      chk(frame_err, 0, "R11 shape kept as pulse");
      cfg_short = 1'b0; cfg_level = 1'b0;
      idle(2);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule